// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI host from a fast main clock. The main clock first passes a power-of-two prescaler whose ratio is picked by a 2-bit select, giving divide-by-2, 4, 8 or 16. A linear divider then counts prescaler ticks and toggles the serial clock after every (baud + 1) ticks. One full serial period therefore spans 2 × (baud + 1) × (2 << select) main-clock cycles.

The linear divider setting has a floor of 4. Any smaller value is raised to 4 in hardware, so the fastest serial clock is main/20 and the slowest is main/2048. A polarity input chooses the idle level of the polarity-adjusted output. Two single-cycle strobes, asserted in the cycle before the raw serial clock rises or falls, tell a shift engine when to launch and when to capture. The configuration inputs are expected to stay stable while the enable is high.

A small state machine sequences the output. Its states are ST_IDLE (disabled, both counters cleared, raw clock low), ST_LOW (raw clock low and counting) and ST_HIGH (raw clock high and counting). Its transitions are:
- arm: ST_IDLE to ST_LOW when the enable is high.
- rise: ST_LOW to ST_HIGH when a half period ends.
- fall: ST_HIGH to ST_LOW when a half period ends.
- halt: any state to ST_IDLE when the enable is low.

Top module: `spi_sclk_gen`

## Requirements
- R1: The prescaler ratio is 2 << div_sel main cycles per tick, so div_sel values 0, 1, 2 and 3 give ratios of 2, 4, 8 and 16.
- R2: With enable held high, sclk_raw is a square wave. Its half period H = (B + 1) × (2 << div_sel) main cycles, and its full period is 2H, where B is the effective baud value.
- R3: The effective baud value B equals baud when baud ≥ 4, and equals 4 when baud is 0 to 3. The shortest half period is therefore 10 cycles.
- R4: While enable is low, sclk_raw is 0, sclk equals cpol, lead_stb and trail_stb are 0, and both counters are held at zero. Each enable therefore starts timing from scratch.
- R5: If the first clock edge that samples enable high is edge t0, sclk_raw rises at edge t0 + H.
- R6: lead_stb is high for exactly one main cycle: the cycle immediately before sclk_raw goes from 0 to 1.
- R7: trail_stb is high for exactly one main cycle: the cycle immediately before an enabled 1-to-0 change of sclk_raw. The two strobes are never high together.
- R8: sclk equals sclk_raw XOR cpol, so with cpol = 1 the clock idles high.
- R9: An edge that samples enable low forces sclk_raw to 0 after that edge, whatever the phase.
- R10: After reset, sclk_raw and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the idle state |
| div_sel | input | 2 | Prescaler select, ratio 2 << div_sel |
| baud | input | 6 | Linear divider setting, clamped to at least 4 |
| cpol | input | 1 | Idle level of sclk (1 = idle high) |
| sclk_raw | output | 1 | Serial clock before polarity adjustment |
| sclk | output | 1 | Polarity-adjusted serial clock |
| lead_stb | output | 1 | One-cycle strobe before sclk_raw rises |
| trail_stb | output | 1 | One-cycle strobe before sclk_raw falls |

## Verification
The hardest case to reach from the ports is the first half period after an enable that follows a disable in mid-phase. A fault that leaves a stale count in either counter only shows up as a shortened first edge.

The stimulus sets up this case on purpose. It drops enable while sclk_raw is high and partway through a half period, then re-enables and measures the latency to the first rising edge against H.

The clamp is reached by programming baud values of 0 and 3 and expecting the same period as a baud value of 4.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/spi_sclk_prescale.sv
module spi_sclk_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int PRE_MAX = 2 << ((1 << DIV_W) - 1);
    localparam int PRE_W   = $clog2(PRE_MAX);

    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] last;
    logic [PRE_W-1:0] cnt;

    always_comb begin
        span = (PRE_W+1)'(2) << div_sel;
        last = PRE_W'(span - 1'b1);
        tick = !hold && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_sclk_baudcnt.sv
module spi_sclk_baudcnt #(
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             step,
    input  logic [BRG_W-1:0] baud,
    output logic             half_done
);
    localparam logic [BRG_W-1:0] FLOOR = BRG_W'(BRG_MIN);

    logic [BRG_W-1:0] brg_eff;
    logic [BRG_W-1:0] cnt;

    always_comb begin
        brg_eff   = (baud < FLOOR) ? FLOOR : baud;
        half_done = !hold && step && (cnt == brg_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || half_done) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int DIV_W   = 2,
    parameter int BRG_W   = 6,
    parameter int BRG_MIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [BRG_W-1:0] baud,
    input  logic             cpol,
    output logic             sclk_raw,
    output logic             sclk,
    output logic             lead_stb,
    output logic             trail_stb
);
    import spi_sclk_pkg::*;

    sclk_state_e state, state_nx;
    logic        hold;
    logic        tick;
    logic        half_done;

    assign hold = (state == ST_IDLE) || !en;

    spi_sclk_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .div_sel (div_sel),
        .tick    (tick)
    );

    spi_sclk_baudcnt #(.BRG_W(BRG_W), .BRG_MIN(BRG_MIN)) u_brg (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .step      (tick),
        .baud      (baud),
        .half_done (half_done)
    );

    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_LOW;
                ST_LOW:  if (half_done) state_nx = ST_HIGH;
                ST_HIGH: if (half_done) state_nx = ST_LOW;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        sclk_raw  = 1'b0;
        lead_stb  = 1'b0;
        trail_stb = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_LOW:  lead_stb = half_done;
            ST_HIGH: begin
                sclk_raw  = 1'b1;
                trail_stb = half_done;
            end
            default: ;
        endcase
        sclk = sclk_raw ^ cpol;
    end
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
    parameter int BRG_MIN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cpol,
    input logic sclk_raw,
    input logic sclk,
    input logic lead_stb,
    input logic trail_stb
);
    localparam int HMIN = 2 * (BRG_MIN + 1);

    logic [15:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (!en || lead_stb || trail_stb) begin
            gap <= '0;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 1'b1;
        end
    end

    assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sclk_raw && !lead_stb && !trail_stb));

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (sclk == cpol));

    assert_lead_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb && en) |=> $rose(sclk_raw));

    assert_rise_has_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_raw) |-> $past(lead_stb));

    assert_trail_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && en) |=> $fell(sclk_raw));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lead_stb, trail_stb}) <= 1);

    assert_min_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_stb || trail_stb) |-> (gap >= 16'(HMIN - 1)));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.BRG_MIN(BRG_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cpol      (cpol),
    .sclk_raw  (sclk_raw),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb)
);

// File: tb/sim_spi_sclk_gen.sv
`timescale 1ns/1ps
module sim_spi_sclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic [5:0] baud = 6'd4;
    logic       cpol = 1'b0;
    logic       sclk_raw, sclk, lead_stb, trail_stb;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    spi_sclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .baud(baud),
        .cpol(cpol), .sclk_raw(sclk_raw), .sclk(sclk),
        .lead_stb(lead_stb), .trail_stb(trail_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: samples 1 ns after each rising edge
    int  since_en = 0;
    int  since_rise = 0;
    bit  first = 1'b1;
    bit  p_raw = 1'b0, p_lead = 1'b0, p_trail = 1'b0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                since_rise++;
                if (!en) begin
                    since_en = 0;
                    first = 1'b1;
                end else begin
                    since_en++;
                end
                if (sclk_raw && !p_raw) begin
                    chk(p_lead, "R6", int'(p_lead), 1);
                    if (exp_q.size() > 0) begin
                        int    e;
                        string t;
                        int    m;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        m = first ? since_en - 1 : since_rise;
                        chk(m == e, t, m, e);
                    end
                    since_rise = 0;
                    first = 1'b0;
                end
                if (!sclk_raw && p_raw && en) chk(p_trail, "R7", int'(p_trail), 1);
                if (lead_stb && p_lead) chk(1'b0, "R6", 2, 1);
                if (trail_stb && p_trail) chk(1'b0, "R7", 2, 1);
                if (lead_stb && trail_stb) chk(1'b0, "R7", 2, 1);
                p_raw = sclk_raw;
                p_lead = lead_stb;
                p_trail = trail_stb;
            end
        end
    end

    task automatic idle_check();
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1;
            chk(!sclk_raw && !lead_stb && !trail_stb, "R4",
                int'({sclk_raw, lead_stb, trail_stb}), 0);
            chk(sclk == cpol, "R8", int'(sclk), int'(cpol));
        end
    endtask

    task automatic run_cfg(input int d, input int b, input bit pol, input int nper, input string tag);
        int beff;
        int h;
        @(negedge clk);
        en = 1'b0;
        div_sel = 2'(d);
        baud = 6'(b);
        cpol = pol;
        idle_check();
        beff = (b < 4) ? 4 : b;
        h = (beff + 1) * (2 << d);
        exp_q.push_back(h);
        tag_q.push_back("R5");
        for (int i = 0; i < nper; i++) begin
            exp_q.push_back(2 * h);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        en = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        #1;
        chk(!sclk_raw, "R9", int'(sclk_raw), 0);
        chk(sclk == cpol, "R8", int'(sclk), int'(cpol));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!sclk_raw && !lead_stb && !trail_stb, "R10",
            int'({sclk_raw, lead_stb, trail_stb}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        run_cfg(0, 4, 1'b0, 2, "R1");
        run_cfg(1, 4, 1'b0, 2, "R1");
        run_cfg(2, 4, 1'b0, 2, "R1");
        run_cfg(3, 4, 1'b0, 2, "R1");
        run_cfg(0, 5, 1'b0, 2, "R2");
        run_cfg(0, 63, 1'b0, 2, "R2");
        run_cfg(3, 63, 1'b0, 1, "R2");
        run_cfg(1, 0, 1'b0, 2, "R3");
        run_cfg(2, 3, 1'b0, 2, "R3");
        run_cfg(0, 4, 1'b1, 2, "R8");

        // disable while high, mid-half; then re-enable from a clean count
        @(negedge clk);
        div_sel = 2'd1;
        baud = 6'd6;
        cpol = 1'b0;
        en = 1'b1;
        repeat (28 + 9) @(negedge clk);
        chk(sclk_raw, "R2", int'(sclk_raw), 1);
        en = 1'b0;
        @(posedge clk);
        #1;
        chk(!sclk_raw, "R9", int'(sclk_raw), 0);
        idle_check();
        run_cfg(1, 6, 1'b0, 1, "R4");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule